// File: doc/BRIEF.md
# Sample-to-beat packer with overflow

The block accepts one narrow signed sample on every clock edge from a source that never waits. Each sample is sign-extended to a 16-bit lane, and consecutive lanes are packed into a wide beat. Each completed beat is written into a small FIFO, and the FIFO is read out over a valid/ready stream.

A start pulse arms a capture of a programmed number of beats. The final beat of the capture carries a last marker. When the downstream side falls behind and the FIFO is full, a completed beat is discarded instead of stalling the source. A sticky flag records the loss, and the discarded beat still counts toward the frame total, so the capture always ends after the same number of cycles.

Top module: `sample_beat_packer`

## Requirements
- R1: While reset is held and just after it, out_valid, busy and overflow are all 0.
- R2: A start pulse with frames = N > 0 sets busy at that edge. The first sample packed is the one presented on the next edge. With frames = 0, busy stays 0 and no beat is produced.
- R3: Each sample is sign-extended to 16 bits: bit SAMPLE_W-1 is copied into lane bits [15:SAMPLE_W].
- R4: Lane i of beat k (bits [16*i+15:16*i]) holds the sample from edge 4k+i+1 after the start edge (for LANES = BUS_W/16 = 4). Lane 0 holds the earliest sample.
- R5: A beat becomes visible on out_valid after the edge that packs its highest lane. For beat 0 this is the fourth edge after start, and out_valid is 0 before that edge.
- R6: Beats leave in the order they were completed. While out_valid is high and out_ready is low, out_data and out_last hold still.
- R7: If the FIFO already holds FIFO_DEPTH beats on the edge where a beat completes, that beat is discarded and overflow becomes 1. When the capture fits exactly into the FIFO, no beat is dropped.
- R8: overflow stays 1 until the next start pulse, and that pulse clears it.
- R9: A discarded beat still counts toward frames. busy falls on the edge that completes beat N-1. While idle, samples have no effect on the output stream.
- R10: out_last is 1 only on the stored beat with index N-1 of the capture. If that beat was discarded, no output beat is marked last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that arms a new capture |
| frames | input | FRAME_W | Number of beats to capture, sampled on start |
| sample_in | input | SAMPLE_W | Signed sample, taken on every edge while capturing |
| out_valid | output | 1 | FIFO head holds a beat |
| out_ready | input | 1 | Downstream accepts the head beat |
| out_data | output | BUS_W | Packed beat, lane 0 in the low bits |
| out_last | output | 1 | Head beat is the final beat of its capture |
| busy | output | 1 | Capture in progress |
| overflow | output | 1 | Sticky: a completed beat was discarded |

## Verification
A lane index that has slipped puts samples in the wrong lane on the very next beat, which is at most four cycles away, and also shifts busy's falling edge. A wrong FIFO count or pointer shows up as a repeated, missing or reordered beat as soon as the FIFO is drained. It can also raise overflow early, or leave it low after more than FIFO_DEPTH undrained beats. A miscounted frame total moves the last marker and the end of capture by whole beats, so comparing every received beat against its arithmetic value, together with the cycle on which busy falls, exposes each of these faults.

// File: rtl/sample_beat_packer.sv
`timescale 1ns/1ps
module sample_beat_packer #(
  parameter int SAMPLE_W   = 12,
  parameter int BUS_W      = 64,
  parameter int FIFO_DEPTH = 4,
  parameter int FRAME_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [FRAME_W-1:0]  frames,
  input  logic [SAMPLE_W-1:0] sample_in,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [BUS_W-1:0]    out_data,
  output logic                out_last,
  output logic                busy,
  output logic                overflow
);
  localparam int LANES  = BUS_W / 16;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int PTR_W  = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(LANES - 1);
  localparam logic [PTR_W-1:0]  TOP_PTR  = PTR_W'(FIFO_DEPTH - 1);
  localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(FIFO_DEPTH);

  logic [LANE_W-1:0]  lane;
  logic [FRAME_W-1:0] beats_done, frames_q;
  logic [BUS_W-1:0]   acc, beat;
  logic [15:0]        ext;
  logic [BUS_W-1:0]   mem_data [FIFO_DEPTH];
  logic               mem_last [FIFO_DEPTH];
  logic [PTR_W-1:0]   wptr, rptr;
  logic [CNT_W-1:0]   count;
  logic               beat_done, fifo_full, push, pop, beat_last;

  assign ext       = 16'($signed(sample_in));
  assign beat_done = busy && !start && (lane == TOP_LANE);
  assign fifo_full = (count == FULL_CNT);
  assign push      = beat_done && !fifo_full;
  assign pop       = out_valid && out_ready;
  assign beat_last = (beats_done == frames_q - 1'b1);

  generate
    if (LANES > 1) begin : g_multi
      assign beat = {ext, acc[BUS_W-17:0]};
    end else begin : g_single
      assign beat = ext;
    end
  endgenerate

  assign out_valid = (count != '0);
  assign out_data  = mem_data[rptr];
  assign out_last  = mem_last[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      overflow   <= 1'b0;
      lane       <= '0;
      beats_done <= '0;
      frames_q   <= '0;
      acc        <= '0;
    end else if (start) begin
      busy       <= (frames != '0);
      frames_q   <= frames;
      lane       <= '0;
      beats_done <= '0;
      overflow   <= 1'b0;
    end else if (busy) begin
      acc[lane*16 +: 16] <= ext;
      lane <= (lane == TOP_LANE) ? '0 : lane + 1'b1;
      if (beat_done) begin
        beats_done <= beats_done + 1'b1;
        if (beat_last) busy <= 1'b0;
        if (!push) overflow <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem_data[wptr] <= beat;
      mem_last[wptr] <= beat_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == TOP_PTR) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == TOP_PTR) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !start |=> overflow);
  assert_overflow_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(count) == FULL_CNT);
  assert_hold_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  assert_end_on_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(lane) == TOP_LANE) || $past(start));
  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !overflow && (lane == '0));
  always_comb assert_count_bound_R7: assert (count <= FULL_CNT);
endmodule

// File: tb/tb_sample_beat_packer.sv
`timescale 1ns/1ps
module tb_sample_beat_packer;
  localparam int SW = 12, BW = 64, L = BW / 16, D = 4, FW = 16;

  logic clk = 0, rst_n = 0, start = 0, out_ready = 0;
  logic [FW-1:0] frames = '0;
  logic [SW-1:0] sample_in;
  logic out_valid, out_last, busy, overflow;
  logic [BW-1:0] out_data;
  int scnt = 0, ready_mode = 0, total = 0, bad = 0, s0 = 0;
  logic [BW-1:0] rx_data[$];
  logic rx_last[$];

  sample_beat_packer #(.SAMPLE_W(SW), .BUS_W(BW), .FIFO_DEPTH(D), .FRAME_W(FW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .frames(frames), .sample_in(sample_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .busy(busy), .overflow(overflow));

  always #2 clk = ~clk;

  function automatic logic [SW-1:0] pat(int t);
    return SW'(t * 37 + 5);
  endfunction
  function automatic logic [15:0] sx(logic [SW-1:0] v);
    int x = int'(v);
    if (x >= (1 << (SW - 1))) x -= (1 << SW);
    return 16'(x);
  endfunction
  function automatic logic [BW-1:0] exp_beat(int base, int k);
    logic [BW-1:0] b = '0;
    for (int i = 0; i < L; i++) b[16*i +: 16] = sx(pat(base + 1 + L * k + i));
    return b;
  endfunction

  assign sample_in = pat(scnt);

  always begin
    @(posedge clk); #1;
    scnt = scnt + 1;
    out_ready = (ready_mode == 1) || (ready_mode == 2 && scnt[0]);
  end

  always @(negedge clk) if (rst_n && out_valid && out_ready) begin
    rx_data.push_back(out_data);
    rx_last.push_back(out_last);
  end

  task automatic chk(bit ok, string req, logic [BW-1:0] act, logic [BW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_start(int n);
    @(posedge clk); #1;
    frames = FW'(n); start = 1;
    @(negedge clk); s0 = scnt;
    @(posedge clk); #1; start = 0;
  endtask

  task automatic check_rx(string req, int first_k, int n, int last_idx);
    chk(rx_data.size() == n, {req, " beat count"}, BW'(rx_data.size()), BW'(n));
    for (int j = 0; j < n && j < rx_data.size(); j++) begin
      chk(rx_data[j] == exp_beat(s0, first_k + j), {req, " beat data"}, rx_data[j], exp_beat(s0, first_k + j));
      chk(rx_last[j] == (j == last_idx), {req, " R10 last flag"}, BW'(rx_last[j]), BW'(j == last_idx));
    end
    rx_data.delete(); rx_last.delete();
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && !busy && !overflow, "R1 reset outputs", BW'({out_valid, busy, overflow}), '0);
    @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    chk(!out_valid && !busy && !overflow, "R1 after reset", BW'({out_valid, busy, overflow}), '0);

    // R2: zero frames
    do_start(0);
    repeat (12) @(posedge clk); @(negedge clk);
    chk(!busy && !out_valid && rx_data.size() == 0, "R2 zero frames", BW'({busy, out_valid}), '0);

    // R2 R3 R4 R10: three beats, free drain
    ready_mode = 1;
    do_start(3);
    @(negedge clk);
    chk(busy, "R2 busy after start", BW'(busy), 1);
    repeat (18) @(posedge clk); @(negedge clk);
    chk(!busy && !overflow, "R9 three-beat end", BW'({busy, overflow}), '0);
    check_rx("R4 three beats", 0, 3, 2);

    // R5 R6 R7 R9: stalled, six beats into depth four
    ready_mode = 0;
    do_start(6);
    repeat (3) @(posedge clk); @(negedge clk);
    chk(!out_valid, "R5 not yet valid", BW'(out_valid), 0);
    @(posedge clk); @(negedge clk);
    chk(out_valid, "R5 valid after fourth edge", BW'(out_valid), 1);
    chk(out_data == exp_beat(s0, 0), "R6 head beat", out_data, exp_beat(s0, 0));
    repeat (19) @(posedge clk); @(negedge clk);
    chk(busy, "R9 busy before last beat", BW'(busy), 1);
    @(posedge clk); @(negedge clk);
    chk(!busy, "R9 dropped beats counted", BW'(busy), 0);
    chk(overflow, "R7 overflow set", BW'(overflow), 1);
    repeat (10) @(posedge clk); @(negedge clk);
    chk(overflow, "R8 overflow sticky", BW'(overflow), 1);
    chk(out_data == exp_beat(s0, 0) && !out_last, "R6 held while stalled", out_data, exp_beat(s0, 0));
    ready_mode = 1;
    repeat (10) @(posedge clk); @(negedge clk);
    check_rx("R7 surviving beats", 0, 4, -1);
    chk(overflow && !out_valid, "R8 survives drain", BW'({overflow, out_valid}), 2);

    // R7 R8: exact fit clears and stays clear
    ready_mode = 0;
    do_start(4);
    @(negedge clk);
    chk(!overflow, "R8 start clears overflow", BW'(overflow), 0);
    repeat (20) @(posedge clk); @(negedge clk);
    chk(!overflow && !busy, "R7 exact fit no drop", BW'({overflow, busy}), '0);
    ready_mode = 1;
    repeat (8) @(posedge clk); @(negedge clk);
    check_rx("R7 exact fit", 0, 4, 3);

    // R9: idle samples ignored
    repeat (40) @(posedge clk); @(negedge clk);
    chk(!out_valid && rx_data.size() == 0, "R9 idle ignored", BW'(rx_data.size()), '0);

    // R6: alternating ready
    ready_mode = 2;
    do_start(20);
    repeat (90) @(posedge clk); @(negedge clk);
    chk(!overflow, "R6 no drop at half ready", BW'(overflow), 0);
    check_rx("R6 alternating ready", 0, 20, 19);

    // R3: every sample code
    ready_mode = 1;
    do_start(1 << (SW - 2));
    repeat ((1 << SW) + 10) @(posedge clk); @(negedge clk);
    chk(!overflow && !busy, "R3 sweep end", BW'({overflow, busy}), '0);
    check_rx("R3 full code sweep", 0, 1 << (SW - 2), (1 << (SW - 2)) - 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule